// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block steps an external dual-slope integrating converter through its conversion phases. A two-bit phase code is driven onto the converter's phase-select lines. The phases repeat in a fixed ring: auto-zero, integrate, de-integrate, integrator-zero, and then auto-zero again. The integrate and auto-zero lengths both come from one 8-bit load value that software writes through a write strobe. The integrator-zero length is fixed.

The de-integrate phase ends when the converter's zero-crossing comparator goes from high to low. The comparator first passes through a two-flop synchronizer. While de-integrate runs, the block counts system clocks. When it leaves de-integrate it presents a result: the count, an overrange flag and a polarity flag. A one-cycle strobe marks the new result.

The state machine has four states, named after their phase codes:
- `PH_AZ` (01) goes to `PH_INT` when its timer expires.
- `PH_INT` (10) goes to `PH_DEINT` when its timer expires.
- `PH_DEINT` (11) goes to `PH_IZ` on a synchronized comparator fall or when the count saturates.
- `PH_IZ` (00) goes to `PH_AZ` when its timer expires.

Top module: `dslope_phase_seq`

## Requirements
- R1: `phase_ab` (bit 1 = A, bit 0 = B) carries 01 in auto-zero, 10 in integrate, 11 in de-integrate and 00 in integrator-zero. Phases advance only in the order 01 → 10 → 11 → 00 → 01.
- R2: With active load value L, auto-zero and integrate each last (L+1)·2^TICK_W clock cycles. Integrator-zero lasts 2^TICK_W cycles.
- R3: A cycle with `load_wr` high stores `load_data`. The stored value becomes active on the next entry into auto-zero, and that auto-zero and the following integrate both use it. A write never changes the length of the phase in progress.
- R4: `cmp_in` is synchronized by two flops. A falling edge on `cmp_in` applied in de-integrate cycle j (cycle 1 is the first) ends de-integrate after cycle j+2. A falling edge seen outside de-integrate has no effect on any phase length.
- R5: On a comparator-ended de-integrate, `result_cnt` equals the number of de-integrate cycles minus one (j+1 for a fall applied in cycle j), and `result_ovr` is 0.
- R6: If the count reaches 2^CNT_W−1 with no fall in that cycle, de-integrate ends after 2^CNT_W cycles with `result_ovr`=1 and `result_cnt` all ones. A fall that coincides with the maximum count gives `result_ovr`=0.
- R7: `result_pol` is the synchronized comparator level in the last integrate cycle (1 = positive input).
- R8: `result_valid` is high for exactly the first integrator-zero cycle after each de-integrate. The result outputs change only with it.
- R9: Reset (synchronous, active high) gives auto-zero, a load value of 0, `result_valid`=0 and all result outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_wr | input | 1 | Write strobe for the load value |
| load_data | input | LOAD_W | Load value to store |
| cmp_in | input | 1 | Zero-crossing comparator from the converter (asynchronous) |
| phase_ab | output | 2 | Phase code: bit 1 = A, bit 0 = B |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result_ovr | output | 1 | Overrange flag of the last result |
| result_pol | output | 1 | Polarity of the last result (1 = positive) |
| result_cnt | output | CNT_W | De-integrate clock count of the last result |

## Verification
Some properties are checked by assertions on every cycle:
- the phase ring order;
- a timed phase never leaves before its timer expires;
- the active load value stays fixed except at auto-zero entry;
- the strobe lasts one cycle and lines up with the de-integrate-to-integrator-zero step;
- the synchronized fall pulse lasts one cycle;
- an overrange result carries an all-ones count.

Other behaviours need the bench's scenarios:
- exact phase lengths for each load value, including a rewrite in mid-integrate;
- the count for a fall placed in a chosen de-integrate cycle;
- saturation, and a fall that lands on the maximum count;
- polarity taken at the end of integrate;
- comparator glitches during integrate that must not disturb it.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        PH_IZ    = 2'b00,
        PH_AZ    = 2'b01,
        PH_INT   = 2'b10,
        PH_DEINT = 2'b11
    } phase_e;

    function automatic phase_e phase_succ(phase_e p);
        phase_e n;
        unique case (p)
            PH_AZ:    n = PH_INT;
            PH_INT:   n = PH_DEINT;
            PH_DEINT: n = PH_IZ;
            PH_IZ:    n = PH_AZ;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dslope_cmp_sync.sv
module dslope_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_in,
    output logic level,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], cmp_in};
    end

    assign level = chain[STAGES-1];
    assign fall  = chain[STAGES] & ~chain[STAGES-1];

    // R4: a single edge yields a single-cycle pulse
    assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/dslope_phase_timer.sv
module dslope_phase_timer #(
    parameter int LOAD_W = 8,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic [LOAD_W:0]   units,
    output logic              expired
);
    localparam int REM_W = LOAD_W + TICK_W;

    logic [REM_W-1:0] rem;
    logic [REM_W:0]   full;
    logic [REM_W:0]   full_m1;

    assign full    = {units, {TICK_W{1'b0}}};
    assign full_m1 = full - {{REM_W{1'b0}}, 1'b1};
    assign expired = (rem == '0);

    always_ff @(posedge clk) begin
        if (rst)           rem <= {{LOAD_W{1'b0}}, {TICK_W{1'b1}}};
        else if (reload)   rem <= full_m1[REM_W-1:0];
        else if (!expired) rem <= rem - 1'b1;
    end

endmodule

// File: rtl/dslope_deint_count.sv
module dslope_deint_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_deint,
    input  logic             fall,
    input  logic             pol_take,
    input  logic             level,
    output logic             done,
    output logic             result_valid,
    output logic             result_ovr,
    output logic             result_pol,
    output logic [CNT_W-1:0] result_cnt
);
    logic [CNT_W-1:0] cnt;
    logic             pol_hold;
    logic             at_max;

    assign at_max = &cnt;
    assign done   = in_deint && (fall || at_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (in_deint && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_hold     <= 1'b0;
            result_valid <= 1'b0;
            result_ovr   <= 1'b0;
            result_pol   <= 1'b0;
            result_cnt   <= '0;
        end else begin
            if (pol_take) pol_hold <= level;
            result_valid <= done;
            if (done) begin
                result_cnt <= cnt;
                result_ovr <= !fall;
                result_pol <= pol_hold;
            end
        end
    end

    // R8: strobe lasts exactly one cycle
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R6: an overrange result always reports a saturated count
    assert_ovr_saturated_R6: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result_ovr) |-> (&result_cnt));

endmodule

// File: rtl/dslope_phase_seq.sv
module dslope_phase_seq #(
    parameter int LOAD_W      = 8,
    parameter int TICK_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_wr,
    input  logic [LOAD_W-1:0] load_data,
    input  logic              cmp_in,
    output logic [1:0]        phase_ab,
    output logic              result_valid,
    output logic              result_ovr,
    output logic              result_pol,
    output logic [CNT_W-1:0]  result_cnt
);
    import dslope_pkg::*;

    phase_e            state, state_nx;
    logic [LOAD_W-1:0] load_reg, load_act;
    logic [LOAD_W:0]   units;
    logic              expired, reload;
    logic              cmp_level, cmp_fall;
    logic              deint_done;

    dslope_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cmp_in(cmp_in),
        .level(cmp_level), .fall(cmp_fall)
    );

    dslope_phase_timer #(.LOAD_W(LOAD_W), .TICK_W(TICK_W)) u_timer (
        .clk(clk), .rst(rst), .reload(reload), .units(units),
        .expired(expired)
    );

    dslope_deint_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst),
        .start(state == PH_INT && state_nx == PH_DEINT),
        .in_deint(state == PH_DEINT),
        .fall(cmp_fall),
        .pol_take(state == PH_INT && expired),
        .level(cmp_level),
        .done(deint_done),
        .result_valid(result_valid),
        .result_ovr(result_ovr),
        .result_pol(result_pol),
        .result_cnt(result_cnt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_AZ:    if (expired)    state_nx = PH_INT;
            PH_INT:   if (expired)    state_nx = PH_DEINT;
            PH_DEINT: if (deint_done) state_nx = PH_IZ;
            PH_IZ:    if (expired)    state_nx = PH_AZ;
        endcase
    end

    // timer length for the phase being entered
    always_comb begin
        reload = (state_nx != state);
        unique case (state_nx)
            PH_AZ:   units = {1'b0, load_reg} + 1'b1;
            PH_INT:  units = {1'b0, load_act} + 1'b1;
            default: units = {{LOAD_W{1'b0}}, 1'b1};
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PH_AZ;
        else     state <= state_nx;
    end

    // load value registers
    always_ff @(posedge clk) begin
        if (rst) begin
            load_reg <= '0;
            load_act <= '0;
        end else begin
            if (load_wr) load_reg <= load_data;
            if (state_nx == PH_AZ && state != PH_AZ) load_act <= load_reg;
        end
    end

    // outputs
    always_comb begin
        phase_ab = state;
    end

    // R1: the ring order is never broken
    assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> (state == phase_succ($past(state))));

    // R2: a timed phase holds until its timer runs out
    assert_timed_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state != PH_DEINT && !expired) |=> (state == $past(state)));

    // R3: the active load value only moves on entry to auto-zero
    assert_load_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (state != PH_IZ) |=> $stable(load_act));

    // R8: strobe appears only on the first integrator-zero cycle
    assert_valid_align_R8: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (state == PH_IZ && $past(state) == PH_DEINT));

endmodule

// File: tb/dslope_phase_seq_tb.sv
module dslope_phase_seq_tb;
    localparam int LOAD_W = 8;
    localparam int TICK_W = 3;
    localparam int CNT_W  = 8;
    localparam int UNIT   = 1 << TICK_W;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam logic [1:0] C_IZ = 2'b00, C_AZ = 2'b01, C_INT = 2'b10, C_DE = 2'b11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_wr = 1'b0;
    logic [LOAD_W-1:0] load_data = '0;
    logic              cmp_in = 1'b0;
    logic [1:0]        phase_ab;
    logic              result_valid, result_ovr, result_pol;
    logic [CNT_W-1:0]  result_cnt;

    dslope_phase_seq #(.LOAD_W(LOAD_W), .TICK_W(TICK_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .load_wr(load_wr), .load_data(load_data), .cmp_in(cmp_in),
        .phase_ab(phase_ab), .result_valid(result_valid), .result_ovr(result_ovr),
        .result_pol(result_pol), .result_cnt(result_cnt)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int bench_load = 0;
    int exp_act = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_succ(input logic [1:0] p);
        case (p)
            C_AZ:    return C_INT;
            C_INT:   return C_DE;
            C_DE:    return C_IZ;
            default: return C_AZ;
        endcase
    endfunction

    function automatic int exp_len(input logic [1:0] p, input int act);
        if (p == C_IZ) return UNIT;
        return (act + 1) * UNIT;
    endfunction

    // phase monitor: ring order (R1), phase lengths (R2, R3), glitch immunity (R4)
    logic [1:0] prev_ph = C_AZ;
    int run_len = 0;
    bit first_run = 1;
    always @(negedge clk) begin
        if (!rst) begin
            if (phase_ab != prev_ph) begin
                check(phase_ab == exp_succ(prev_ph), "R1 order", phase_ab, exp_succ(prev_ph));
                if (prev_ph != C_DE && !(first_run && prev_ph == C_AZ))
                    check(run_len == exp_len(prev_ph, exp_act), "R2/R3/R4 phase length",
                          run_len, exp_len(prev_ph, exp_act));
                first_run = 0;
                if (phase_ab == C_AZ) exp_act = bench_load;
                prev_ph = phase_ab;
                run_len = 1;
            end else begin
                run_len++;
            end
        end
    end

    // one conversion: fall in deint cycle j (0 = none), polarity, glitch in integrate, optional load write
    task automatic run_conv(input int j, input bit pol, input bit glitch, input bit do_load, input int new_load);
        int n;
        int exp_cnt;
        bit exp_ovr;
        do @(negedge clk); while (phase_ab != C_AZ);
        do @(negedge clk); while (phase_ab != C_INT);
        if (glitch) begin
            cmp_in = 1'b1; @(negedge clk);
            cmp_in = 1'b0; @(negedge clk);
        end
        cmp_in = pol;
        if (do_load) begin
            load_wr = 1'b1; load_data = new_load[LOAD_W-1:0];
            @(negedge clk);
            load_wr = 1'b0;
            bench_load = new_load;
        end
        do @(negedge clk); while (phase_ab != C_DE);
        n = 1;
        if (!pol) cmp_in = 1'b1;
        if (j == 1) cmp_in = 1'b0;
        forever begin
            @(negedge clk);
            if (phase_ab != C_DE) break;
            n++;
            if (n == j) cmp_in = 1'b0;
        end
        exp_cnt = (j > 0) ? j + 1 : CMAX;
        exp_ovr = (j == 0);
        check(result_valid == 1'b1, "R8 strobe on first IZ cycle", result_valid, 1);
        check(int'(result_cnt) == exp_cnt, (j > 0) ? "R5 count" : "R6 saturated count",
              result_cnt, exp_cnt);
        check(result_ovr == exp_ovr, "R6 overrange flag", result_ovr, exp_ovr);
        check(n == exp_cnt + 1, "R4/R5 deint length", n, exp_cnt + 1);
        check(result_pol == pol, "R7 polarity", result_pol, pol);
        cmp_in = 1'b0;
        @(negedge clk);
        check(result_valid == 1'b0, "R8 strobe single cycle", result_valid, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        check(phase_ab == C_AZ, "R9 reset phase", phase_ab, C_AZ);
        check(result_valid == 1'b0, "R9 reset strobe", result_valid, 0);
        check(result_cnt == '0, "R9 reset count", result_cnt, 0);
        check(result_ovr == 1'b0 && result_pol == 1'b0, "R9 reset flags",
              {result_ovr, result_pol}, 0);
        rst = 1'b0;
        // directed corners
        run_conv(5, 1'b1, 1'b0, 1'b0, 0);             // R9 load 0 lengths, R5
        run_conv(0, 1'b1, 1'b0, 1'b0, 0);             // R6 saturation
        run_conv(CMAX - 1, 1'b1, 1'b0, 1'b0, 0);      // R6 fall on max count
        run_conv(6, 1'b0, 1'b1, 1'b1, 255);           // R3 write mid-integrate, R4 glitch, R7 negative
        run_conv(4, 1'b1, 1'b0, 1'b1, 2);             // R3 long phases then shorter
        run_conv(0, 1'b0, 1'b1, 1'b0, 0);             // R6 negative saturation
        // constrained random
        for (int k = 0; k < 14; k++) begin
            int jj;
            bit pp, gg, ll;
            int nl;
            jj = ($urandom % 8 == 0) ? 0 : 4 + int'($urandom % 197);
            pp = 1'($urandom % 2);
            gg = 1'($urandom % 2);
            ll = 1'($urandom % 2);
            nl = int'($urandom % 64);
            run_conv(jj, pp, gg, ll, nl);
        end
        // let one more full ring be length-checked by the monitor
        do @(negedge clk); while (phase_ab != C_INT);
        do @(negedge clk); while (phase_ab != C_DE);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule